// File: doc/BRIEF.md
# Two-Channel LED Driver Start-Up Sequencer

This block is the digital controller that brings a two-string LED backlight driver from rest to regulation. It watches a supply-good flag, the combined enable/dimming input and a flag that reports the oscillator-select pin being pulled low. When these allow a start, it closes the input disconnect switch. Once the switch gate reports ready, it classifies every LED pin from comparator flags, and it holds off any further progress while a pin is shorted to ground.

After a classification window of a fixed number of switching cycles, each channel is marked as in use or unused. The sequencer then enters soft start, with reduced sink current and the low switch-current limit. It passes to full regulation once the LED pins report enough headroom. In regulation a low enable acts as dimming: sinks and boost stop while the sequencer keeps its state. An enable held low for a long count is taken as a power-down.

Analog comparators, current sinks and the boost loop are outside the block and appear only as flags. One clock cycle equals one switching cycle.

Top module: `led_startup_seq`

## Requirements
- R1: After synchronous reset, disc_en, soft_start, run_out, sink_en and ch_mask are all 0.
- R2: A start begins only when uvlo_ok=1, en_in=1 and fpin_low=0 are sampled together in idle. disc_en then goes to 1 at that same clock edge, and ch_mask is cleared to 0.
- R3: While gate_rdy is 0 after the switch is enabled, classification does not run and soft_start stays 0.
- R4: Classification completes only after DET_WAIT consecutive cycles in which every pin has lvl_gt120=1 and lvl_gt70=1. A single cycle with any pin's lvl_gt120=0 restarts the count from zero.
- R5: A pin with lvl_gt70=0 during classification halts the start, keeping disc_en=1 and soft_start=0, for as long as the short lasts. On release, a full DET_WAIT window runs again.
- R6: At the end of the window, ch_mask bit i takes lvl_gt325[i]: 1 means in use, and 0 means the pin sits near the unused level. sink_en bit i is never 1 where ch_mask bit i is 0.
- R7: soft_start is 1 from the end of the window until the edge that samples headroom_ok=1. At that edge soft_start falls and run_out rises.
- R8: In regulation, en_in=0 drops run_out and sink_en to 0 at the next edge while disc_en stays 1. en_in=1 restores them at the next edge with no new classification.
- R9: In regulation, en_in held 0 for OFF_LIMIT consecutive sampled cycles returns the block to idle: disc_en falls at the OFF_LIMIT-th edge.
- R10: en_in=0 during switch enable, classification, short hold or soft start returns the block to idle at the next edge, and so does uvlo_ok=0 in any state.
- R11: ch_mask keeps its value through soft start, regulation and shutdown until the next start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | switching-rate clock |
| rst | input | 1 | synchronous active-high reset |
| uvlo_ok | input | 1 | supply above lockout threshold |
| en_in | input | 1 | enable / PWM dimming input |
| fpin_low | input | 1 | oscillator-select pin held low |
| gate_rdy | input | 1 | disconnect-switch gate reached its threshold |
| lvl_gt70 | input | NCH | pin above the short-to-ground level, per channel |
| lvl_gt120 | input | NCH | pin above the arming level, per channel |
| lvl_gt325 | input | NCH | pin above the in-use level, per channel |
| headroom_ok | input | 1 | LED pins have enough voltage to leave soft start |
| disc_en | output | 1 | input disconnect switch enable |
| soft_start | output | 1 | reduced sink current and low switch limit selected |
| run_out | output | 1 | boost and sinks active at full level |
| ch_mask | output | NCH | channels classified as in use |
| sink_en | output | NCH | per-channel sink enable |

## Verification
Every output is a register loaded from the next-state decode, so each result appears at the very edge that samples its stimulus. The classification window closes on the DET_WAIT-th qualifying edge, and the shutdown on the OFF_LIMIT-th low edge. The bench drives inputs just after a falling edge and compares all outputs at the next falling edge against a behavioural model, so every check sits half a cycle after the edge that should produce the change. Directed checks land on both sides of each window boundary, at DET_WAIT-1 and DET_WAIT edges and at OFF_LIMIT-1 and OFF_LIMIT edges.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_GATE   = 3'd1,
    SQ_DETECT = 3'd2,
    SQ_HOLD   = 3'd3,
    SQ_SOFT   = 3'd4,
    SQ_RUN    = 3'd5
  } seq_state_t;
endpackage

// File: rtl/led_pin_classifier.sv
module led_pin_classifier #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] lvl_gt70,
  input  logic [NCH-1:0] lvl_gt120,
  input  logic [NCH-1:0] lvl_gt325,
  output logic           any_short,
  output logic           all_armed,
  output logic [NCH-1:0] in_use
);
  logic [NCH-1:0] short_v;
  logic [NCH-1:0] armed_v;

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    // below the lowest level: pin tied to ground
    assign short_v[i] = ~lvl_gt70[i];
    // armed once above 120 mV and not shorted
    assign armed_v[i] = lvl_gt120[i] & lvl_gt70[i];
    // only the top level marks a populated string
    assign in_use[i]  = lvl_gt325[i];
  end

  assign any_short = |short_v;
  assign all_armed = &armed_v;
endmodule

// File: rtl/led_dwell_counter.sv
module led_dwell_counter #(
  parameter int LIMIT = 3500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = inc && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= done ? '0 : cnt + 1'b1;
  end

  AST_DWELL_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R4
endmodule

// File: rtl/led_startup_seq.sv
module led_startup_seq #(
  parameter int NCH       = 2,
  parameter int DET_WAIT  = 3500,
  parameter int OFF_LIMIT = 32750
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           uvlo_ok,
  input  logic           en_in,
  input  logic           fpin_low,
  input  logic           gate_rdy,
  input  logic [NCH-1:0] lvl_gt70,
  input  logic [NCH-1:0] lvl_gt120,
  input  logic [NCH-1:0] lvl_gt325,
  input  logic           headroom_ok,
  output logic           disc_en,
  output logic           soft_start,
  output logic           run_out,
  output logic [NCH-1:0] ch_mask,
  output logic [NCH-1:0] sink_en
);
  import led_seq_pkg::*;

  seq_state_t     state_q, state_d;
  logic [NCH-1:0] mask_d;
  logic           any_short, all_armed;
  logic [NCH-1:0] in_use;
  logic           det_done, off_done;
  logic           det_clr, det_inc, off_clr, off_inc;

  led_pin_classifier #(.NCH(NCH)) u_cls (
    .lvl_gt70 (lvl_gt70),
    .lvl_gt120(lvl_gt120),
    .lvl_gt325(lvl_gt325),
    .any_short(any_short),
    .all_armed(all_armed),
    .in_use   (in_use)
  );

  // classification window: consecutive armed cycles
  assign det_inc = (state_q == SQ_DETECT) && all_armed && !any_short;
  assign det_clr = !det_inc;

  led_dwell_counter #(.LIMIT(DET_WAIT)) u_det (
    .clk (clk),
    .rst (rst),
    .clr (det_clr),
    .inc (det_inc),
    .done(det_done)
  );

  // long-low enable in regulation
  assign off_inc = (state_q == SQ_RUN) && !en_in;
  assign off_clr = !off_inc;

  led_dwell_counter #(.LIMIT(OFF_LIMIT)) u_off (
    .clk (clk),
    .rst (rst),
    .clr (off_clr),
    .inc (off_inc),
    .done(off_done)
  );

  always_comb begin
    state_d = state_q;
    mask_d  = ch_mask;
    if (!uvlo_ok) begin
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (en_in && !fpin_low) begin
          state_d = SQ_GATE;
          mask_d  = '0;
        end
        SQ_GATE: begin
          if (!en_in)        state_d = SQ_IDLE;
          else if (gate_rdy) state_d = SQ_DETECT;
        end
        SQ_DETECT: begin
          if (!en_in)         state_d = SQ_IDLE;
          else if (any_short) state_d = SQ_HOLD;
          else if (det_done) begin
            state_d = SQ_SOFT;
            mask_d  = in_use;
          end
        end
        SQ_HOLD: begin
          if (!en_in)          state_d = SQ_IDLE;
          else if (!any_short) state_d = SQ_DETECT;
        end
        SQ_SOFT: begin
          if (!en_in)           state_d = SQ_IDLE;
          else if (headroom_ok) state_d = SQ_RUN;
        end
        SQ_RUN: if (off_done) state_d = SQ_IDLE;
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  logic sinks_on_d;
  assign sinks_on_d = (state_d == SQ_SOFT) || ((state_d == SQ_RUN) && en_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      ch_mask    <= '0;
      disc_en    <= 1'b0;
      soft_start <= 1'b0;
      run_out    <= 1'b0;
      sink_en    <= '0;
    end else begin
      state_q    <= state_d;
      ch_mask    <= mask_d;
      disc_en    <= (state_d != SQ_IDLE);
      soft_start <= (state_d == SQ_SOFT);
      run_out    <= (state_d == SQ_RUN) && en_in;
      sink_en    <= mask_d & {NCH{sinks_on_d}};
    end
  end

  AST_NO_START_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_IDLE && fpin_low) |=> !disc_en); // R2
  AST_GATE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_GATE && !gate_rdy) |=> !soft_start); // R3
  AST_SHORT_BLOCKS_SOFT: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_DETECT && any_short) |=> !soft_start); // R5
  AST_SINK_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    (sink_en & ~ch_mask) == '0); // R6
  AST_RUN_WITH_SWITCH: assert property (@(posedge clk) disable iff (rst)
    run_out |-> (disc_en && !soft_start)); // R8
  AST_UVLO_DROP: assert property (@(posedge clk) disable iff (rst)
    !uvlo_ok |=> !disc_en); // R10
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_SOFT || state_q == SQ_RUN) |=> $stable(ch_mask)); // R11
endmodule

// File: tb/led_startup_seq_test.sv
module led_startup_seq_test;
  localparam int NCH = 2;
  localparam int DW  = 3500;
  localparam int OL  = 32750;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uvlo_ok = 0, en_in = 0, fpin_low = 0, gate_rdy = 0, headroom_ok = 0;
  logic [NCH-1:0] lvl_gt70 = '1, lvl_gt120 = '0, lvl_gt325 = '0;
  logic disc_en, soft_start, run_out;
  logic [NCH-1:0] ch_mask, sink_en;

  int tests = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  led_startup_seq #(.NCH(NCH), .DET_WAIT(DW), .OFF_LIMIT(OL)) uut (
    .clk(clk), .rst(rst), .uvlo_ok(uvlo_ok), .en_in(en_in), .fpin_low(fpin_low),
    .gate_rdy(gate_rdy), .lvl_gt70(lvl_gt70), .lvl_gt120(lvl_gt120),
    .lvl_gt325(lvl_gt325), .headroom_ok(headroom_ok), .disc_en(disc_en),
    .soft_start(soft_start), .run_out(run_out), .ch_mask(ch_mask), .sink_en(sink_en)
  );

  // behavioural reference: 0 idle,1 gate,2 detect,3 hold,4 soft,5 run
  int m_st = 0, m_dcnt = 0, m_ocnt = 0;
  logic [NCH-1:0] m_mask = '0, m_sink = '0;
  logic m_disc = 0, m_soft = 0, m_run = 0;

  always @(posedge clk) begin
    int nst;
    bit arm, sh, on;
    if (rst) begin
      m_st = 0; m_dcnt = 0; m_ocnt = 0; m_mask = '0;
      m_disc = 0; m_soft = 0; m_run = 0; m_sink = '0;
    end else begin
      nst = m_st;
      sh  = (lvl_gt70 != '1);
      arm = ((lvl_gt120 & lvl_gt70) == '1);
      if (m_st != 5) m_ocnt = 0;
      if (!uvlo_ok) nst = 0;
      else case (m_st)
        0: if (en_in && !fpin_low) begin nst = 1; m_mask = '0; end
        1: if (!en_in) nst = 0; else if (gate_rdy) begin nst = 2; m_dcnt = 0; end
        2: if (!en_in) nst = 0;
           else if (sh) begin nst = 3; m_dcnt = 0; end
           else if (arm) begin
             if (m_dcnt == DW - 1) begin nst = 4; m_mask = lvl_gt325; end
             else m_dcnt++;
           end else m_dcnt = 0;
        3: if (!en_in) nst = 0; else if (!sh) begin nst = 2; m_dcnt = 0; end
        4: if (!en_in) nst = 0; else if (headroom_ok) nst = 5;
        5: if (en_in) m_ocnt = 0;
           else if (m_ocnt == OL - 1) begin nst = 0; m_ocnt = 0; end
           else m_ocnt++;
        default: nst = 0;
      endcase
      m_disc = (nst != 0);
      m_soft = (nst == 4);
      m_run  = (nst == 5) && en_in;
      on     = (nst == 4) || ((nst == 5) && en_in);
      m_sink = on ? m_mask : '0;
      m_st = nst;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      tests++;
      if (disc_en !== m_disc) begin fails++; $display("FAIL R2 disc_en act=%b exp=%b t=%0t", disc_en, m_disc, $time); end
      if (soft_start !== m_soft) begin fails++; $display("FAIL R7 soft_start act=%b exp=%b t=%0t", soft_start, m_soft, $time); end
      if (run_out !== m_run) begin fails++; $display("FAIL R8 run_out act=%b exp=%b t=%0t", run_out, m_run, $time); end
      if (ch_mask !== m_mask) begin fails++; $display("FAIL R11 ch_mask act=%b exp=%b t=%0t", ch_mask, m_mask, $time); end
      if (sink_en !== m_sink) begin fails++; $display("FAIL R6 sink_en act=%b exp=%b t=%0t", sink_en, m_sink, $time); end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    step(4);
    chk("R1 disc_en", {7'b0, disc_en}, 8'h0);
    chk("R1 outputs", {2'b0, ch_mask, sink_en, soft_start, run_out}, 8'h0);
    rst = 0;
    // blocked start: oscillator pin low
    uvlo_ok = 1; en_in = 1; fpin_low = 1;
    step(6);
    chk("R2 no start with fpin_low", {7'b0, disc_en}, 8'h0);
    // blocked start: lockout not clear
    fpin_low = 0; uvlo_ok = 0;
    step(6);
    chk("R2 no start without uvlo", {7'b0, disc_en}, 8'h0);
    uvlo_ok = 1;
    step(1);
    chk("R2 switch enabled", {7'b0, disc_en}, 8'h1);
    // pins armed but gate not ready
    lvl_gt120 = 2'b11; lvl_gt325 = 2'b01;
    step(DW + 50);
    chk("R3 waits for gate", {7'b0, soft_start}, 8'h0);
    // gate ready, window with one dip
    lvl_gt120 = 2'b01; gate_rdy = 1;
    step(20);
    lvl_gt120 = 2'b11;
    step(2000);
    lvl_gt120 = 2'b10;
    step(1);
    lvl_gt120 = 2'b11;
    step(DW - 1);
    chk("R4 window not yet closed", {7'b0, soft_start}, 8'h0);
    step(1);
    chk("R4 window closed", {7'b0, soft_start}, 8'h1);
    chk("R6 mask ch0 used ch1 unused", {6'b0, ch_mask}, 8'h1);
    chk("R6 sinks follow mask", {6'b0, sink_en}, 8'h1);
    step(10);
    headroom_ok = 1;
    step(1);
    chk("R7 soft start ends", {6'b0, soft_start, run_out}, 8'h1);
    // dimming low
    en_in = 0;
    step(1);
    chk("R8 dim off", {4'b0, disc_en, run_out, sink_en}, 8'h8);
    step(100);
    en_in = 1;
    step(1);
    chk("R8 dim resume", {5'b0, run_out, sink_en}, 8'h5);
    // long low enable
    en_in = 0;
    step(OL - 1);
    chk("R9 still powered", {7'b0, disc_en}, 8'h1);
    step(1);
    chk("R9 shut down", {7'b0, disc_en}, 8'h0);
    chk("R11 mask held after shutdown", {6'b0, ch_mask}, 8'h1);
    // restart with ch1 shorted
    lvl_gt70 = 2'b01; lvl_gt120 = 2'b01; lvl_gt325 = 2'b01;
    en_in = 1;
    step(1);
    chk("R11 mask cleared at start", {6'b0, ch_mask}, 8'h0);
    step(DW + 500);
    chk("R5 halted on short", {6'b0, disc_en, soft_start}, 8'h2);
    lvl_gt70 = 2'b11; lvl_gt120 = 2'b11; lvl_gt325 = 2'b11;
    step(1);
    step(DW - 1);
    chk("R5 full window after release", {7'b0, soft_start}, 8'h0);
    step(1);
    chk("R5 soft start after release", {7'b0, soft_start}, 8'h1);
    chk("R6 both used", {6'b0, ch_mask}, 8'h3);
    // enable low during soft start
    headroom_ok = 0;
    step(2);
    en_in = 0;
    step(1);
    chk("R10 idle from soft start", {6'b0, disc_en, soft_start}, 8'h0);
    // lockout loss while running
    en_in = 1; headroom_ok = 1;
    step(DW + 10);
    chk("R7 running again", {7'b0, run_out}, 8'h1);
    uvlo_ok = 0;
    step(1);
    chk("R10 lockout drop", {6'b0, disc_en, run_out}, 8'h0);
    step(5);
    finish_run();
  end
endmodule